// File: doc/BRIEF.md
# Two-Level Address Translation Front End

This block turns virtual addresses into physical addresses for two requesters, an instruction-fetch side and a data-access side. Each side has its own small shadow translation buffer. All of its valid entries are compared at once, and a hit there answers in one cycle. Behind both shadows sits one larger unified translation buffer.

When a side misses in its shadow, it competes for the unified buffer through a fixed-priority arbiter, and the data side wins a tie. The unified buffer walks its entries one per cycle and stops at the first match. A match is returned to the requester and also copied into that side's shadow, replacing shadow slots in rotating order. If no entry matches, the requester gets a miss indication that it raises as a translation exception.

A requester holds its request, address and process ID steady until it sees a one-cycle done pulse. The pulse carries either a hit with the physical address or a miss flag. Each entry holds a page number, a page-size code, a process tag and a physical page number. The unified buffer is filled through a simple write port. A single invalidate strobe empties both shadows.

Top module: `two_level_tlb`

## Requirements
- R1: A request that hits in its own shadow gives a done pulse with hit=1 and the physical address in the first clock edge after the request is presented (latency 1), without using the unified buffer.
- R2: Page-size code s (0 to 7) gives a page of 2^(10+2s) bytes. The page number bits va[31:10+2s] must equal the entry's stored page field (which holds va[31:10]) at the same bit positions. The physical address is {rpn,10'b0} above bit 10+2s-1, joined with va below it.
- R3: An entry whose process tag is 0 matches any process ID. Any other tag matches only an equal process ID, so process ID 0 matches only tag-0 entries. This applies at both levels.
- R4: A shadow miss that matches unified entry k (index from 0) completes with hit after k+2 edges.
- R5: A request matching no unified entry completes with miss=1 and hit=0 after UTLB_DEPTH+1 edges. A unified walk never lasts more than UTLB_DEPTH cycles.
- R6: A unified hit writes the matching entry into the requester's shadow, so the same request repeated afterwards completes with latency 1.
- R7: Shadow refills fill slots 0,1,2,... and wrap around to slot 0, evicting the entry that the slot held.
- R8: If both sides want the unified buffer in the same cycle, the data side is served first. The instruction side is granted in the cycle after the data side completes, so its latency is kd+ki+4. Only one side waits on the unified buffer at a time.
- R9: A one-cycle invalidate clears every shadow entry of both sides. It wins over a refill in the same cycle.
- R10: done is a single-cycle pulse raised only for a side that is requesting. Exactly one of hit and miss is 1 while done is 1, and both are 0 otherwise.
- R11: After reset, no done is raised, every shadow and unified entry is invalid, and the first request therefore misses.
- R12: When several unified entries match, the lowest index wins, because the walk stops at the first match.
- R13: A unified write at an index takes effect from the next edge. Writing valid=0 removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iReq | input | 1 | Instruction-side request, held until iDone |
| iVaddr | input | 32 | Instruction-side virtual address |
| iPid | input | 8 | Instruction-side process ID |
| iDone | output | 1 | Instruction-side completion pulse |
| iHit | output | 1 | Translation found (valid with iDone) |
| iMiss | output | 1 | Translation miss, raise exception (valid with iDone) |
| iPaddr | output | 32 | Instruction-side physical address |
| dReq | input | 1 | Data-side request, held until dDone |
| dVaddr | input | 32 | Data-side virtual address |
| dPid | input | 8 | Data-side process ID |
| dDone | output | 1 | Data-side completion pulse |
| dHit | output | 1 | Translation found (valid with dDone) |
| dMiss | output | 1 | Translation miss (valid with dDone) |
| dPaddr | output | 32 | Data-side physical address |
| shadowInval | input | 1 | Clear all shadow entries |
| utlbWrEn | input | 1 | Unified buffer write strobe |
| utlbWrIdx | input | 5 | Unified entry index to write |
| utlbWrValid | input | 1 | Valid bit of written entry |
| utlbWrEpn | input | 22 | Page field (va[31:10]) of written entry |
| utlbWrSize | input | 3 | Page-size code of written entry |
| utlbWrTid | input | 8 | Process tag of written entry |
| utlbWrRpn | input | 22 | Physical page field of written entry |

## Verification
Two pairs of functions can land in the same cycle. The first is a shadow miss on both sides at once, which the bench provokes by launching both requests at the same negative edge into empty shadows. It judges the result by the exact latencies kd+2 for the data side and kd+ki+4 for the instruction side. The second is an invalidate strobe on the very edge that a refill writes a shadow slot. It is provoked by timing the strobe to the known completion edge, and it is judged by the repeated request taking the full unified latency again rather than hitting in one cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ADDR_W  = 32;
  localparam int PID_W   = 8;
  localparam int SIZE_W  = 3;
  localparam int MIN_OFF = 10;
  localparam int EPN_W   = ADDR_W - MIN_OFF;

  typedef struct packed {
    logic               valid;
    logic [EPN_W-1:0]   epn;
    logic [SIZE_W-1:0]  size;
    logic [PID_W-1:0]   tid;
    logic [EPN_W-1:0]   rpn;
  } tlbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic scanStart;
    logic scanStep;
    logic ownerD;
    logic iTakeShadow;
    logic dTakeShadow;
    logic iTakeScan;
    logic dTakeScan;
  } tlbCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic iShadowHit;
    logic dShadowHit;
    logic scanHit;
    logic scanLast;
  } tlbStat_t;

  function automatic logic [ADDR_W-1:0] offMask(logic [SIZE_W-1:0] sz);
    logic [ADDR_W-1:0] one;
    one = 1;
    return (one << (MIN_OFF + 2 * int'(sz))) - one;
  endfunction

  function automatic logic entryHit(tlbEntry_t e, logic [ADDR_W-1:0] va,
                                    logic [PID_W-1:0] pid);
    logic [ADDR_W-1:0] keep;
    keep = ~offMask(e.size);
    return e.valid
        && ((({e.epn, {MIN_OFF{1'b0}}} ^ va) & keep) == '0)
        && ((e.tid == '0) || (e.tid == pid));
  endfunction

  function automatic logic [ADDR_W-1:0] pageXlate(tlbEntry_t e, logic [ADDR_W-1:0] va);
    logic [ADDR_W-1:0] low;
    low = offMask(e.size);
    return ({e.rpn, {MIN_OFF{1'b0}}} & ~low) | (va & low);
  endfunction
endpackage

// File: rtl/tlb_shadow.sv
module tlb_shadow
  import tlb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inval,
  input  logic [ADDR_W-1:0] va,
  input  logic [PID_W-1:0]  pid,
  output logic              hit,
  output logic [ADDR_W-1:0] pa,
  input  logic              refill,
  input  tlbEntry_t         refillEntry
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tlbEntry_t        ent [DEPTH];
  logic [IDX_W-1:0] rrPtr;
  logic [DEPTH-1:0] validVec;

  // parallel compare of all entries, lowest index wins
  always_comb begin
    hit = 1'b0;
    pa  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (entryHit(ent[i], va, pid)) begin
        hit = 1'b1;
        pa  = pageXlate(ent[i], va);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) validVec[i] = ent[i].valid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      rrPtr <= '0;
    end else if (inval) begin
      for (int i = 0; i < DEPTH; i++) ent[i].valid <= 1'b0;
    end else if (refill) begin
      ent[rrPtr] <= refillEntry;
      if (int'(rrPtr) == DEPTH - 1) rrPtr <= '0;
      else rrPtr <= rrPtr + 1'b1;
    end
  end

  // R9
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    inval |=> (validVec == '0));

  // R6
  refill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refill && !inval && refillEntry.valid) |=> ($countones(validVec) >= 1));
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int SHADOW_DEPTH = 4,
  parameter int UTLB_DEPTH   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbCtrl_t          ctrl,
  output tlbStat_t          stat,
  input  logic              shadowInval,
  input  logic [ADDR_W-1:0] iVaddr,
  input  logic [PID_W-1:0]  iPid,
  input  logic [ADDR_W-1:0] dVaddr,
  input  logic [PID_W-1:0]  dPid,
  input  logic              wrEn,
  input  logic [$clog2(UTLB_DEPTH)-1:0] wrIdx,
  input  tlbEntry_t         wrEntry,
  output logic [ADDR_W-1:0] iPaddr,
  output logic [ADDR_W-1:0] dPaddr
);
  localparam int UIDX_W = $clog2(UTLB_DEPTH);

  tlbEntry_t         utlb [UTLB_DEPTH];
  logic [UIDX_W-1:0] scanPtr;
  tlbEntry_t         scanEntry;
  logic [ADDR_W-1:0] scanVa;
  logic [PID_W-1:0]  scanPid;
  logic [ADDR_W-1:0] scanPa;
  logic [ADDR_W-1:0] iShadowPa;
  logic [ADDR_W-1:0] dShadowPa;
  logic              iShadowHit;
  logic              dShadowHit;

  tlb_shadow #(.DEPTH(SHADOW_DEPTH)) u_iShadow (
    .clk(clk), .rstN(rstN), .inval(shadowInval),
    .va(iVaddr), .pid(iPid), .hit(iShadowHit), .pa(iShadowPa),
    .refill(ctrl.iTakeScan), .refillEntry(scanEntry)
  );

  tlb_shadow #(.DEPTH(SHADOW_DEPTH)) u_dShadow (
    .clk(clk), .rstN(rstN), .inval(shadowInval),
    .va(dVaddr), .pid(dPid), .hit(dShadowHit), .pa(dShadowPa),
    .refill(ctrl.dTakeScan), .refillEntry(scanEntry)
  );

  // unified storage and write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < UTLB_DEPTH; i++) utlb[i] <= '0;
    end else if (wrEn && (int'(wrIdx) < UTLB_DEPTH)) begin
      utlb[wrIdx] <= wrEntry;
    end
  end

  // sequential walk pointer
  always_ff @(posedge clk) begin
    if (!rstN) scanPtr <= '0;
    else if (ctrl.scanStart) scanPtr <= '0;
    else if (ctrl.scanStep) scanPtr <= scanPtr + 1'b1;
  end

  assign scanEntry = utlb[scanPtr];
  assign scanVa    = ctrl.ownerD ? dVaddr : iVaddr;
  assign scanPid   = ctrl.ownerD ? dPid : iPid;
  assign scanPa    = pageXlate(scanEntry, scanVa);

  always_comb begin
    stat.iShadowHit = iShadowHit;
    stat.dShadowHit = dShadowHit;
    stat.scanHit    = entryHit(scanEntry, scanVa, scanPid);
    stat.scanLast   = (int'(scanPtr) == UTLB_DEPTH - 1);
  end

  // result address registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      iPaddr <= '0;
      dPaddr <= '0;
    end else begin
      if (ctrl.iTakeShadow) iPaddr <= iShadowPa;
      else if (ctrl.iTakeScan) iPaddr <= scanPa;
      if (ctrl.dTakeShadow) dPaddr <= dShadowPa;
      else if (ctrl.dTakeScan) dPaddr <= scanPa;
    end
  end

  // R6
  refill_on_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.iTakeScan || ctrl.dTakeScan) |-> stat.scanHit);

  // R5
  no_step_past_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.scanStep |-> !stat.scanLast);
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int UTLB_DEPTH = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     iReq,
  input  logic     dReq,
  input  tlbStat_t stat,
  output tlbCtrl_t ctrl,
  output logic     iDone,
  output logic     iHit,
  output logic     iMiss,
  output logic     dDone,
  output logic     dHit,
  output logic     dMiss
);
  localparam int CNT_W = $clog2(UTLB_DEPTH + 2);

  typedef enum logic {U_IDLE, U_SCAN} uState_t;

  uState_t    uState;
  logic       ownerQ;
  logic       iWait;
  logic       dWait;
  logic       iWant;
  logic       dWant;
  logic       grantI;
  logic       grantD;
  logic       scanning;
  logic       finish;
  logic       iFinish;
  logic       dFinish;
  logic [CNT_W-1:0] scanCycles;

  always_comb begin
    iWant    = iReq && !iWait && !stat.iShadowHit;
    dWant    = dReq && !dWait && !stat.dShadowHit;
    grantD   = (uState == U_IDLE) && dWant;
    grantI   = (uState == U_IDLE) && !dWant && iWant;
    scanning = (uState == U_SCAN);
    finish   = scanning && (stat.scanHit || stat.scanLast);
    iFinish  = finish && !ownerQ;
    dFinish  = finish && ownerQ;

    ctrl.scanStart   = grantD || grantI;
    ctrl.scanStep    = scanning && !finish;
    ctrl.ownerD      = ownerQ;
    ctrl.iTakeShadow = iReq && !iWait && stat.iShadowHit;
    ctrl.dTakeShadow = dReq && !dWait && stat.dShadowHit;
    ctrl.iTakeScan   = iFinish && stat.scanHit;
    ctrl.dTakeScan   = dFinish && stat.scanHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uState <= U_IDLE;
      ownerQ <= 1'b0;
      iWait  <= 1'b0;
      dWait  <= 1'b0;
    end else begin
      case (uState)
        U_IDLE: if (grantD || grantI) begin
          uState <= U_SCAN;
          ownerQ <= grantD;
        end
        U_SCAN: if (finish) uState <= U_IDLE;
        default: uState <= U_IDLE;
      endcase
      if (grantI) iWait <= 1'b1;
      else if (iFinish) iWait <= 1'b0;
      if (grantD) dWait <= 1'b1;
      else if (dFinish) dWait <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iDone <= 1'b0; iHit <= 1'b0; iMiss <= 1'b0;
      dDone <= 1'b0; dHit <= 1'b0; dMiss <= 1'b0;
    end else begin
      iDone <= ctrl.iTakeShadow || iFinish;
      iHit  <= ctrl.iTakeShadow || ctrl.iTakeScan;
      iMiss <= iFinish && !stat.scanHit;
      dDone <= ctrl.dTakeShadow || dFinish;
      dHit  <= ctrl.dTakeShadow || ctrl.dTakeScan;
      dMiss <= dFinish && !stat.scanHit;
    end
  end

  // walk length monitor
  always_ff @(posedge clk) begin
    if (!rstN) scanCycles <= '0;
    else if (scanning) scanCycles <= scanCycles + 1'b1;
    else scanCycles <= '0;
  end

  // R5
  walk_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanning |-> (int'(scanCycles) < UTLB_DEPTH));

  // R8
  data_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((uState == U_IDLE) && dWant && iWant) |=> (dWait && !iWait));

  // R8
  single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({iWait, dWait}));

  // R10
  i_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    iDone ? (iHit != iMiss) : (!iHit && !iMiss));

  // R10
  d_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    dDone ? (dHit != dMiss) : (!dHit && !dMiss));

  // R10
  i_done_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    iDone |-> $past(iReq));

  // R10
  d_done_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    dDone |-> $past(dReq));
endmodule

// File: rtl/two_level_tlb.sv
module two_level_tlb
  import tlb_pkg::*;
#(
  parameter int SHADOW_DEPTH = 4,
  parameter int UTLB_DEPTH   = 32,
  localparam int UIDX_W      = $clog2(UTLB_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               iReq,
  input  logic [ADDR_W-1:0]  iVaddr,
  input  logic [PID_W-1:0]   iPid,
  output logic               iDone,
  output logic               iHit,
  output logic               iMiss,
  output logic [ADDR_W-1:0]  iPaddr,
  input  logic               dReq,
  input  logic [ADDR_W-1:0]  dVaddr,
  input  logic [PID_W-1:0]   dPid,
  output logic               dDone,
  output logic               dHit,
  output logic               dMiss,
  output logic [ADDR_W-1:0]  dPaddr,
  input  logic               shadowInval,
  input  logic               utlbWrEn,
  input  logic [UIDX_W-1:0]  utlbWrIdx,
  input  logic               utlbWrValid,
  input  logic [EPN_W-1:0]   utlbWrEpn,
  input  logic [SIZE_W-1:0]  utlbWrSize,
  input  logic [PID_W-1:0]   utlbWrTid,
  input  logic [EPN_W-1:0]   utlbWrRpn
);
  tlbCtrl_t  ctrl;
  tlbStat_t  stat;
  tlbEntry_t wrEntry;

  always_comb begin
    wrEntry.valid = utlbWrValid;
    wrEntry.epn   = utlbWrEpn;
    wrEntry.size  = utlbWrSize;
    wrEntry.tid   = utlbWrTid;
    wrEntry.rpn   = utlbWrRpn;
  end

  tlb_control #(.UTLB_DEPTH(UTLB_DEPTH)) u_control (
    .clk(clk), .rstN(rstN), .iReq(iReq), .dReq(dReq),
    .stat(stat), .ctrl(ctrl),
    .iDone(iDone), .iHit(iHit), .iMiss(iMiss),
    .dDone(dDone), .dHit(dHit), .dMiss(dMiss)
  );

  tlb_datapath #(.SHADOW_DEPTH(SHADOW_DEPTH), .UTLB_DEPTH(UTLB_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stat(stat),
    .shadowInval(shadowInval),
    .iVaddr(iVaddr), .iPid(iPid), .dVaddr(dVaddr), .dPid(dPid),
    .wrEn(utlbWrEn), .wrIdx(utlbWrIdx), .wrEntry(wrEntry),
    .iPaddr(iPaddr), .dPaddr(dPaddr)
  );
endmodule

// File: tb/two_level_tlb_tb.sv
module two_level_tlb_tb;
  localparam int SD = 4;
  localparam int UD = 8;

  logic clk = 0;
  logic rstN = 0;
  logic iReq = 0, dReq = 0;
  logic [31:0] iVaddr = 0, dVaddr = 0;
  logic [7:0]  iPid = 0, dPid = 0;
  logic iDone, iHit, iMiss, dDone, dHit, dMiss;
  logic [31:0] iPaddr, dPaddr;
  logic shadowInval = 0;
  logic utlbWrEn = 0;
  logic [2:0] utlbWrIdx = 0;
  logic utlbWrValid = 0;
  logic [21:0] utlbWrEpn = 0, utlbWrRpn = 0;
  logic [2:0] utlbWrSize = 0;
  logic [7:0] utlbWrTid = 0;

  int checks = 0;
  int fails = 0;

  // bench copy of the unified contents, as written by the bench
  logic        mValid [UD];
  logic [21:0] mEpn [UD];
  logic [2:0]  mSize [UD];
  logic [7:0]  mTid [UD];
  logic [21:0] mRpn [UD];

  always #4 clk = ~clk;

  two_level_tlb #(.SHADOW_DEPTH(SD), .UTLB_DEPTH(UD)) u_dut (
    .clk(clk), .rstN(rstN),
    .iReq(iReq), .iVaddr(iVaddr), .iPid(iPid),
    .iDone(iDone), .iHit(iHit), .iMiss(iMiss), .iPaddr(iPaddr),
    .dReq(dReq), .dVaddr(dVaddr), .dPid(dPid),
    .dDone(dDone), .dHit(dHit), .dMiss(dMiss), .dPaddr(dPaddr),
    .shadowInval(shadowInval),
    .utlbWrEn(utlbWrEn), .utlbWrIdx(utlbWrIdx), .utlbWrValid(utlbWrValid),
    .utlbWrEpn(utlbWrEpn), .utlbWrSize(utlbWrSize), .utlbWrTid(utlbWrTid),
    .utlbWrRpn(utlbWrRpn)
  );

  function automatic logic [31:0] lowMask(int s);
    return (32'd1 << (10 + 2 * s)) - 32'd1;
  endfunction

  function automatic logic [31:0] vaOf(int k);
    return (32'(k + 1) << 28) | (32'h0ABC_DEF7 & lowMask(k));
  endfunction

  function automatic logic [7:0] tidOf(int k);
    return (k % 3 == 0) ? 8'h00 : 8'(k + 16);
  endfunction

  function automatic logic [7:0] pidOf(int k);
    return (tidOf(k) == 0) ? 8'h55 : tidOf(k);
  endfunction

  function automatic logic [21:0] rpnOf(int k);
    return 22'h2A5A5 ^ 22'(k * 22'h1357);
  endfunction

  task automatic modelLookup(input logic [31:0] va, input logic [7:0] pid,
                             output logic hit, output logic [31:0] pa);
    hit = 0; pa = 0;
    for (int k = UD - 1; k >= 0; k--) begin
      logic [31:0] m;
      m = lowMask(int'(mSize[k]));
      if (mValid[k] && ((({mEpn[k], 10'b0} ^ va) & ~m) == 0) &&
          (mTid[k] == 0 || mTid[k] == pid)) begin
        hit = 1;
        pa = ({mRpn[k], 10'b0} & ~m) | (va & m);
      end
    end
  endtask

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input logic v, input logic [21:0] epn,
                            input logic [2:0] sz, input logic [7:0] tid,
                            input logic [21:0] rpn);
    @(negedge clk);
    utlbWrEn = 1; utlbWrIdx = 3'(idx); utlbWrValid = v; utlbWrEpn = epn;
    utlbWrSize = sz; utlbWrTid = tid; utlbWrRpn = rpn;
    mValid[idx] = v; mEpn[idx] = epn; mSize[idx] = sz; mTid[idx] = tid; mRpn[idx] = rpn;
    @(negedge clk);
    utlbWrEn = 0;
  endtask

  task automatic pulseInval();
    @(negedge clk);
    shadowInval = 1;
    @(negedge clk);
    shadowInval = 0;
  endtask

  task automatic doReq(input bit side, input logic [31:0] va, input logic [7:0] pid,
                       output logic hit, output logic miss, output logic [31:0] pa,
                       output int lat);
    bit seen;
    @(negedge clk);
    if (side) begin dReq = 1; dVaddr = va; dPid = pid; end
    else begin iReq = 1; iVaddr = va; iPid = pid; end
    lat = 0; seen = 0; hit = 0; miss = 0; pa = 0;
    while (!seen && lat < 100) begin
      @(posedge clk);
      #2;
      lat++;
      if (side ? dDone : iDone) begin
        seen = 1;
        hit = side ? dHit : iHit;
        miss = side ? dMiss : iMiss;
        pa = side ? dPaddr : iPaddr;
      end
    end
    if (side) dReq = 0; else iReq = 0;
  endtask

  task automatic runCase(input bit side, input logic [31:0] va, input logic [7:0] pid,
                         input int expLat, input string rq);
    logic eHit, hit, miss;
    logic [31:0] ePa, pa;
    int lat;
    modelLookup(va, pid, eHit, ePa);
    doReq(side, va, pid, hit, miss, pa, lat);
    check(rq, "hit", 32'(hit), 32'(eHit));
    check(rq, "miss", 32'(miss), 32'(!eHit));
    if (eHit) check(rq, "paddr", pa, ePa);
    check(rq, "latency", 32'(lat), 32'(expLat));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < UD; k++) begin
      mValid[k] = 0; mEpn[k] = 0; mSize[k] = 0; mTid[k] = 0; mRpn[k] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    check("R11", "iDone", 32'(iDone), 0);
    check("R11", "dDone", 32'(dDone), 0);
    check("R11", "hit/miss", 32'({iHit, iMiss, dHit, dMiss}), 0);
    @(negedge clk);
    rstN = 1;
    // R11 empty buffers: miss after full walk (R5)
    runCase(1, vaOf(2), pidOf(2), UD + 1, "R11");

    // R13 load unified entries: size code k per entry
    for (int k = 0; k < UD; k++)
      writeEntry(k, 1, vaOf(k)[31:10], 3'(k), tidOf(k), rpnOf(k));

    // R4 data-side walks, then R6 repeats hit in shadow (R1)
    for (int k = 0; k < SD; k++) runCase(1, vaOf(k), pidOf(k), k + 2, "R4");
    for (int k = 0; k < SD; k++) runCase(1, vaOf(k), pidOf(k), 1, "R6");

    // R7 rotating replacement
    runCase(1, vaOf(4), pidOf(4), 6, "R7");
    runCase(1, vaOf(0), pidOf(0), 2, "R7");
    runCase(1, vaOf(2), pidOf(2), 1, "R7");
    runCase(1, vaOf(1), pidOf(1), 3, "R7");

    // R2 every page size on the instruction side, R1 shadow hits after
    for (int k = 0; k < UD; k++) runCase(0, vaOf(k), pidOf(k), k + 2, "R2");
    for (int k = SD; k < UD; k++) runCase(0, vaOf(k), pidOf(k), 1, "R1");
    // R2 address bit just above the page offset changes the page
    runCase(0, vaOf(2) ^ 32'h0000_4000, pidOf(2), UD + 1, "R2");

    // R3 process tags
    runCase(0, vaOf(1), 8'h00, UD + 1, "R3");
    runCase(0, vaOf(1), 8'h12, UD + 1, "R3");
    runCase(0, vaOf(5), 8'h16, UD + 1, "R3");
    runCase(0, vaOf(0), 8'h00, 2, "R3");
    runCase(0, vaOf(3), 8'h77, 5, "R3");

    // R9 invalidate clears shadows
    runCase(1, vaOf(3), pidOf(3), 1, "R9");
    pulseInval();
    runCase(1, vaOf(3), pidOf(3), 5, "R9");

    // R9 invalidate on the same edge as a refill
    pulseInval();
    fork
      runCase(1, vaOf(4), pidOf(4), 6, "R9");
      begin
        @(negedge clk);
        repeat (5) @(negedge clk);
        shadowInval = 1;
        @(negedge clk);
        shadowInval = 0;
      end
    join
    runCase(1, vaOf(4), pidOf(4), 6, "R9");

    // R8 simultaneous requests: data first
    pulseInval();
    fork
      runCase(1, vaOf(2), pidOf(2), 4, "R8");
      runCase(0, vaOf(3), pidOf(3), 2 + 3 + 4, "R8");
    join
    pulseInval();
    fork
      runCase(1, vaOf(5), pidOf(5), 7, "R8");
      runCase(0, vaOf(0), pidOf(0), 5 + 0 + 4, "R8");
    join

    // R12 duplicate match: lowest index wins
    pulseInval();
    writeEntry(7, 1, vaOf(2)[31:10], 3'd2, tidOf(2), 22'h11111);
    runCase(0, vaOf(2), pidOf(2), 4, "R12");

    // R13 removing an entry
    pulseInval();
    writeEntry(6, 0, vaOf(6)[31:10], 3'd6, tidOf(6), rpnOf(6));
    runCase(1, vaOf(6), pidOf(6), UD + 1, "R13");

    // R10 no pulse without request
    repeat (3) @(posedge clk);
    #2;
    check("R10", "idle done", 32'({iDone, dDone}), 0);

    summary();
    $finish;
  end
endmodule